// File: doc/BRIEF.md
# Time-Gain Compensation Sequencer

During one ultrasound receive phase the echoes get weaker over time. This block runs the reference-voltage schedule that makes up for it. A start pulse launches a sequence of profile steps, and each step lasts a fixed number of clock cycles. At every step the block presents two 12-bit codes to the reference DACs: an upper code above a common-mode code and a lower code below it, at equal distance. That distance, the half-span, shrinks by a constant ratio of about 0.192 dB per step. The block also drives a 2-bit gain select for the amplifier stage that follows. The gain select rises at three programmed step indices, which keeps the loop gain roughly constant while the reference span narrows.

The half-span follows a fixed-point recurrence, so no stored table is needed. The common-mode code and the three gain thresholds are captured when a sequence starts, and changes to them during a run have no effect. A one-cycle strobe marks each new set of codes. The codes feed DACs paced only by the step interval, so there is no back-pressure and the strobe carries no handshake. A busy flag covers the whole run, and a one-cycle done pulse ends it. After the run the codes stay at their last values.

Top module: `tgc_sequencer`

## Requirements
- R1: While reset is held and right after it is released, busy, done and the strobe are 0, and both codes and the gain select are 0.
- R2: A start pulse sampled while idle makes busy 1 at the next clock edge. At that same edge step 0 is presented with a one-cycle strobe, and `cm_code_i` and `gain_step_i` are captured.
- R3: Step k is presented INTERVAL_CYCLES·k cycles after step 0, for k = 0..NUM_STEPS-1 (default 200 cycles, 125 steps). The strobe is high for exactly one cycle per step, and the outputs stay unchanged between steps.
- R4: The half-span is kept as a value with 16 fraction bits. It starts at HS_START·65536, and each step replaces it with floor(value·DECAY_Q/65536). The integer part (value/65536) is the half-span used for that step. Defaults: HS_START=856, DECAY_Q=64103.
- R5: The upper code is min(cm + hs, 4095) and the lower code is max(cm − hs, 0), where cm is the captured common-mode code.
- R6: The gain select at step k is the number of captured thresholds t with k ≥ t. Value 0..3 selects 9, 16, 24 and 33 dB.
- R7: INTERVAL_CYCLES cycles after the last step, done is high for exactly one cycle and busy falls at the same edge.
- R8: After done, both codes and the gain select keep their final values until the next start, whatever `cm_code_i` does.
- R9: A start pulse, or a change of `cm_code_i` or `gain_step_i`, during a running sequence has no effect on timing or outputs.
- R10: Within a run the gain select never decreases, and the upper code is never below the lower code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a receive phase |
| cm_code_i | input | 12 | Common-mode code, captured at start |
| gain_step_i | input | 3x7 | Step indices at which the gain select advances |
| ref_hi_o | output | 12 | Upper reference DAC code |
| ref_lo_o | output | 12 | Lower reference DAC code |
| gain_sel_o | output | 2 | Second-stage gain select |
| upd_stb_o | output | 1 | One-cycle strobe when new codes appear |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
The bench goes after clamping at both ends of the code range, using a common-mode code near the top and one near the bottom. A design that wraps instead of saturating would jump from a high code to a low one there. Threshold sets include zero (gain already raised at step 0), the final index, and values beyond the last step. An off-by-one in the comparator would move a gain change by one step, or drop it entirely. In one run the bench fires a start pulse and changes the captured inputs halfway through. A design that re-arms or re-samples would restart the count or shift its codes. The bench also checks the exact cycle of done and of every step, so a timer that counts one cycle too many or too few shows up as a strobe in the wrong cycle.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
  localparam int NUM_THR = 3;
  localparam int GAIN_W  = $clog2(NUM_THR + 1);
  typedef logic [GAIN_W-1:0] gain_t;
endpackage

// File: rtl/tgc_timer.sv
module tgc_timer #(
  parameter int INTERVAL_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = $clog2(INTERVAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTERVAL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= '0;
    else if (run_i)  cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tgc_step_ctrl.sv
module tgc_step_ctrl #(
  parameter int NUM_STEPS = 125,
  localparam int IDX_W = $clog2(NUM_STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tick_i,
  output logic             load_o,
  output logic             adv_o,
  output logic [IDX_W-1:0] idx_next_o,
  output logic             busy_o,
  output logic             stb_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_STEPS - 1);

  logic [IDX_W-1:0] step_q;
  logic             busy_q, stb_q, done_q, fin;

  assign load_o     = start_i && !busy_q;
  assign adv_o      = busy_q && tick_i && (step_q != IDX_LAST);
  assign fin        = busy_q && tick_i && (step_q == IDX_LAST);
  assign idx_next_o = load_o ? '0 : step_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
      busy_q <= 1'b0;
      stb_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      stb_q  <= load_o || adv_o;
      done_q <= fin;
      if (load_o) begin
        busy_q <= 1'b1;
        step_q <= '0;
      end else if (adv_o) begin
        step_q <= idx_next_o;
      end else if (fin) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign stb_o  = stb_q;
  assign done_o = done_q;
endmodule

// File: rtl/tgc_profile.sv
module tgc_profile #(
  parameter int CODE_W   = 12,
  parameter int FRAC_W   = 16,
  parameter int HS_START = 856,
  parameter int DECAY_Q  = 64103
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [CODE_W-1:0] cm_i,
  output logic [CODE_W-1:0] hi_o,
  output logic [CODE_W-1:0] lo_o
);
  localparam int ACC_W  = CODE_W + FRAC_W;
  localparam int PROD_W = ACC_W + FRAC_W;
  localparam logic [ACC_W-1:0] ACC_INIT = ACC_W'(HS_START) << FRAC_W;

  logic [ACC_W-1:0]  acc_q, acc_nxt, acc_sel;
  logic [CODE_W-1:0] cm_q, cm_sel, hs, hi_nxt, lo_nxt, hi_q, lo_q;
  logic [CODE_W:0]   sum, dif;

  always_comb begin
    acc_nxt = ACC_W'((PROD_W'(acc_q) * PROD_W'(DECAY_Q)) >> FRAC_W);
    acc_sel = load_i ? ACC_INIT : acc_nxt;
    cm_sel  = load_i ? cm_i : cm_q;
    hs      = acc_sel[ACC_W-1 -: CODE_W];
    sum     = {1'b0, cm_sel} + {1'b0, hs};
    dif     = {1'b0, cm_sel} - {1'b0, hs};
    hi_nxt  = sum[CODE_W] ? '1 : sum[CODE_W-1:0];
    lo_nxt  = dif[CODE_W] ? '0 : dif[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      cm_q  <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (load_i || adv_i) begin
      acc_q <= acc_sel;
      cm_q  <= cm_sel;
      hi_q  <= hi_nxt;
      lo_q  <= lo_nxt;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/tgc_gain.sv
module tgc_gain
  import tgc_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic                          adv_i,
  input  logic [IDX_W-1:0]              idx_next_i,
  input  logic [NUM_THR-1:0][IDX_W-1:0] thr_i,
  output gain_t                         gain_o
);
  logic [NUM_THR-1:0][IDX_W-1:0] thr_q;
  logic [NUM_THR-1:0]            hit;
  gain_t                         gain_nxt, gain_q;

  for (genvar g = 0; g < NUM_THR; g++) begin : g_cmp
    assign hit[g] = idx_next_i >= (load_i ? thr_i[g] : thr_q[g]);
  end

  always_comb begin
    gain_nxt = '0;
    for (int g = 0; g < NUM_THR; g++) gain_nxt = gain_nxt + GAIN_W'(hit[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q  <= '0;
      gain_q <= '0;
    end else begin
      if (load_i) thr_q <= thr_i;
      if (load_i || adv_i) gain_q <= gain_nxt;
    end
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/tgc_sequencer.sv
module tgc_sequencer
  import tgc_pkg::*;
#(
  parameter int NUM_STEPS       = 125,
  parameter int INTERVAL_CYCLES = 200,
  parameter int CODE_W          = 12,
  parameter int FRAC_W          = 16,
  parameter int HS_START        = 856,
  parameter int DECAY_Q         = 64103,
  localparam int IDX_W          = $clog2(NUM_STEPS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [CODE_W-1:0]             cm_code_i,
  input  logic [NUM_THR-1:0][IDX_W-1:0] gain_step_i,
  output logic [CODE_W-1:0]             ref_hi_o,
  output logic [CODE_W-1:0]             ref_lo_o,
  output logic [GAIN_W-1:0]             gain_sel_o,
  output logic                          upd_stb_o,
  output logic                          busy_o,
  output logic                          done_o
);
  logic             load, adv, tick;
  logic [IDX_W-1:0] idx_next;

  tgc_step_ctrl #(.NUM_STEPS(NUM_STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick),
    .load_o(load), .adv_o(adv), .idx_next_o(idx_next),
    .busy_o(busy_o), .stb_o(upd_stb_o), .done_o(done_o)
  );

  tgc_timer #(.INTERVAL_CYCLES(INTERVAL_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load), .run_i(busy_o), .tick_o(tick)
  );

  tgc_profile #(
    .CODE_W(CODE_W), .FRAC_W(FRAC_W), .HS_START(HS_START), .DECAY_Q(DECAY_Q)
  ) u_prof (
    .clk(clk), .rst_n(rst_n), .load_i(load), .adv_i(adv),
    .cm_i(cm_code_i), .hi_o(ref_hi_o), .lo_o(ref_lo_o)
  );

  tgc_gain #(.IDX_W(IDX_W)) u_gain (
    .clk(clk), .rst_n(rst_n), .load_i(load), .adv_i(adv),
    .idx_next_i(idx_next), .thr_i(gain_step_i), .gain_o(gain_sel_o)
  );
endmodule

// File: rtl/tgc_sequencer_chk.sv
module tgc_sequencer_chk #(
  parameter int INTERVAL_CYCLES = 200,
  parameter int CODE_W          = 12,
  parameter int GAIN_W          = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_stb_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [CODE_W-1:0] ref_hi_o,
  input logic [CODE_W-1:0] ref_lo_o,
  input logic [GAIN_W-1:0] gain_sel_o
);
  localparam int GAP_W = $clog2(INTERVAL_CYCLES + 1);
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         gap_q <= '0;
    else if (upd_stb_o) gap_q <= '0;
    else if (busy_o)    gap_q <= gap_q + 1'b1;
  end

  // R3
  stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb_o && busy_o && $past(busy_o)) |-> gap_q == GAP_W'(INTERVAL_CYCLES - 1));

  // R3
  stb_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb_o |-> busy_o);

  // R3
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb_o |-> ($stable(ref_hi_o) && $stable(ref_lo_o) && $stable(gain_sel_o)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R10
  gain_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> gain_sel_o >= $past(gain_sel_o));

  // R10
  ref_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ref_hi_o >= ref_lo_o);
endmodule

bind tgc_sequencer tgc_sequencer_chk #(
  .INTERVAL_CYCLES(INTERVAL_CYCLES), .CODE_W(CODE_W), .GAIN_W(tgc_pkg::GAIN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_stb_o(upd_stb_o), .busy_o(busy_o),
  .done_o(done_o), .ref_hi_o(ref_hi_o), .ref_lo_o(ref_lo_o), .gain_sel_o(gain_sel_o)
);

// File: tb/tgc_sequencer_tb.sv
module tgc_sequencer_tb;
  localparam int NSTEP = 125;
  localparam int INTV  = 200;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [11:0]     cm_code = '0;
  logic [2:0][6:0] thr = '0;
  logic [11:0]     hi, lo;
  logic [1:0]      gain;
  logic            stb, busy, done;

  int nchk = 0;
  int nerr = 0;
  longint hs_tab [NSTEP];

  always #4 clk = ~clk;

  tgc_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cm_code_i(cm_code),
    .gain_step_i(thr), .ref_hi_o(hi), .ref_lo_o(lo), .gain_sel_o(gain),
    .upd_stb_o(stb), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint exp_hi(longint cm, int k);
    longint s = cm + hs_tab[k];
    return (s > 4095) ? 4095 : s;
  endfunction

  function automatic longint exp_lo(longint cm, int k);
    longint d = cm - hs_tab[k];
    return (d < 0) ? 0 : d;
  endfunction

  function automatic int exp_gain(int k, int t0, int t1, int t2);
    return int'(k >= t0) + int'(k >= t1) + int'(k >= t2);
  endfunction

  task automatic run_seq(input int cm, input int t0, input int t1, input int t2,
                         input bit disturb);
    longint eh, el;
    int     eg, badj;
    cm_code = 12'(cm);
    thr[0] = 7'(t0); thr[1] = 7'(t1); thr[2] = 7'(t2);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R2: busy and step 0 right after the start edge
    chk(busy == 1'b1, "R2", "busy after start", longint'(busy), 1);
    for (int k = 0; k < NSTEP; k++) begin
      eh = exp_hi(cm, k); el = exp_lo(cm, k); eg = exp_gain(k, t0, t1, t2);
      chk(stb == 1'b1, "R3", $sformatf("strobe at step %0d", k), longint'(stb), 1);
      chk(longint'(hi) == eh, "R5", $sformatf("upper R4 step %0d", k), longint'(hi), eh);
      chk(longint'(lo) == el, "R5", $sformatf("lower R4 step %0d", k), longint'(lo), el);
      chk(int'(gain) == eg, "R6", $sformatf("gain step %0d", k), longint'(gain), longint'(eg));
      badj = -1;
      for (int j = 1; j < INTV; j++) begin
        @(negedge clk);
        if (disturb && k == 50 && j == 5) begin
          start = 1'b1; cm_code = 12'd777; thr = '0;
        end
        if (disturb && k == 50 && j == 6) start = 1'b0;
        if ((stb || !busy || done || longint'(hi) != eh || longint'(lo) != el ||
             int'(gain) != eg) && badj < 0) badj = j;
      end
      // R3 hold between steps; R9 for disturbed run
      chk(badj < 0, disturb ? "R9" : "R3", $sformatf("quiet cycles after step %0d", k),
          longint'(badj), -1);
      @(negedge clk);
    end
    // R7
    chk(done == 1'b1, "R7", "done after last interval", longint'(done), 1);
    chk(busy == 1'b0, "R7", "busy falls with done", longint'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done one cycle", longint'(done), 0);
    cm_code = ~cm_code;
    repeat (7) @(negedge clk);
    // R8
    chk(longint'(hi) == eh && longint'(lo) == el, "R8", "upper code held",
        longint'(hi), eh);
    chk(int'(gain) == eg && !stb && !busy, "R8", "gain held idle", longint'(gain),
        longint'(eg));
  endtask

  initial begin
    longint acc;
    int rc, r0, r1, r2;
    void'($urandom(32'd20240601));
    acc = 856 << 16;
    for (int k = 0; k < NSTEP; k++) begin
      hs_tab[k] = acc >> 16;
      acc = (acc * 64103) >> 16;
    end
    repeat (4) @(negedge clk);
    // R1
    chk(!busy && !done && !stb, "R1", "control idle in reset",
        longint'({busy, done, stb}), 0);
    chk(hi == 0 && lo == 0 && gain == 0, "R1", "codes zero in reset", longint'(hi), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !stb && hi == 0 && gain == 0, "R1", "idle after reset",
        longint'({busy, stb}), 0);

    run_seq(2048, 30, 70, 105, 1'b0);
    r0 = $urandom_range(0, 124); r1 = $urandom_range(0, 124); r2 = $urandom_range(0, 124);
    run_seq(4000, r0, r1, r2, 1'b0);
    run_seq(100, 0, 0, 124, 1'b1);
    rc = $urandom_range(0, 4095);
    r0 = $urandom_range(0, 127); r1 = $urandom_range(0, 127); r2 = 127;
    run_seq(rc, r0, r1, r2, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule